// File: doc/BRIEF.md
# Banked Scratchpad Datapath with Result Collector

This block is the memory half of a multi-lane scratchpad. A serializer upstream has already resolved bank conflicts. Each cycle it hands this block four things: a mask of the lanes served in that cycle, a bank number and an in-bank word offset for every lane, the write data and byte masks for stores, and a store flag and a last flag that are shared by all lanes. The block steers at most one lane onto each bank and performs the accesses. It then routes each bank's read word back to every lane that named that bank.

An instruction can be spread over several serialized cycles. A per-lane collector keeps each lane's result from the cycle in which that lane was served. When the cycle carrying the last flag has gone through the banks, the block raises a one-cycle valid pulse, and the whole result vector is stable for that pulse. Bank read latency is one cycle. The control that goes with each access is delayed by one register stage, so it arrives together with the read data. The valid pulse and the results it presents therefore appear after the second rising edge that follows the cycle carrying the last flag.

Top module: `spm_bank_datapath`

## Requirements
- R1: While synchronous active-high reset is applied, and in the first cycle after it, `out_valid` is 0 and every lane of `out_rdata` is 0.
- R2: For each bank, the served lane with the lowest index whose bank number equals that bank performs the access. Other served lanes naming the same bank do not write it. A bank is enabled only when at least one served lane names it.
- R3: A store changes only the bytes of the addressed word whose byte-mask bit is 1. Bit k of a lane's mask covers data bits 8k+7..8k.
- R4: Banks are read-first. On a store, each served lane receives the word content from before the write.
- R5: Served lanes that name the same bank and offset on a load all receive the same word.
- R6: A lane's result register loads only when that lane was served. Lanes not served in a cycle keep their earlier value, including values from earlier serialized cycles and earlier instructions.
- R7: `out_valid` is high for exactly one cycle, after the second rising edge that follows a cycle with `in_last` high, and is low otherwise.
- R8: When `out_valid` is high, `out_rdata` holds the bank words read for every lane served in that instruction.
- R9: A lane whose served bit is 0 has no effect on any bank, whatever its address, data or mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_served | input | LANES | Lanes served in this cycle |
| in_bank_idx | input | LANES x BANK_W | Bank number for each lane |
| in_offset | input | LANES x OFF_W | Word offset inside the bank for each lane |
| in_wdata | input | LANES x DATA_W | Store data for each lane |
| in_bmask | input | LANES x WBYTES | Byte write mask for each lane |
| in_store | input | 1 | 1 = store, 0 = load, shared by all lanes |
| in_last | input | 1 | Final serialized cycle of the instruction |
| out_valid | output | 1 | One-cycle pulse: results complete |
| out_rdata | output | LANES x DATA_W | Collected result word for each lane |

## Verification
The bench first makes two served lanes name the same bank on a store, then reads the word back. A design without lowest-first steering leaves the higher lane's data in memory. It also issues a store from an unserved lane and reads that word back; a design that ignores the served mask corrupts it. It then overwrites known words and checks that the store returns the old contents: a write-first bank would return the new data. A partial byte mask must merge with the old word, not replace it. A two-cycle serialized load and a pair of back-to-back single-cycle instructions exercise the valid timing and the per-lane hold. A misaligned control delay would load the wrong lanes, lose earlier-cycle results, or place the valid pulse one cycle early or late.

// File: rtl/spm_dp_pkg.sv
package spm_dp_pkg;

    parameter int LANES  = 4;
    parameter int BANKS  = 4;
    parameter int DEPTH  = 16;
    parameter int WBYTES = 4;

    localparam int BANK_W = $clog2(BANKS);
    localparam int OFF_W  = $clog2(DEPTH);
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int DATA_W = WBYTES * 8;

    typedef logic [BANK_W-1:0] bank_idx_t;
    typedef logic [OFF_W-1:0]  offset_t;
    typedef logic [LANE_W-1:0] lane_sel_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [WBYTES-1:0] bmask_t;

    // One bank's access for one cycle, after steering
    typedef struct packed {
        logic    en;
        logic    we;
        offset_t off;
        word_t   wdata;
        bmask_t  bwe;
    } bank_req_t;

    typedef struct packed {
        logic      hit;
        lane_sel_t idx;
    } pick_t;

    // Lowest-index request wins
    function automatic pick_t pick_lowest(input logic [LANES-1:0] req);
        pick_t p;
        p = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (req[i]) begin
                p.hit = 1'b1;
                p.idx = lane_sel_t'(i);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/spm_bank_steer.sv
module spm_bank_steer
    import spm_dp_pkg::*;
#(
    parameter int BANK_ID = 0
) (
    input  logic [LANES-1:0]             served,
    input  logic [LANES-1:0][BANK_W-1:0] bank_idx,
    input  logic [LANES-1:0][OFF_W-1:0]  offset,
    input  logic [LANES-1:0][DATA_W-1:0] wdata,
    input  logic [LANES-1:0][WBYTES-1:0] bmask,
    input  logic                         store,
    output bank_req_t                    req
);

    logic [LANES-1:0] match;
    pick_t            winner;

    for (genvar l = 0; l < LANES; l++) begin : g_match
        assign match[l] = (bank_idx[l] == bank_idx_t'(BANK_ID));
    end

    assign winner = pick_lowest(served & match);

    always_comb begin
        req       = '0;
        req.en    = winner.hit & served[winner.idx];
        req.we    = req.en & store;
        req.off   = offset[winner.idx];
        req.wdata = wdata[winner.idx];
        req.bwe   = req.we ? bmask[winner.idx] : '0;
    end

endmodule

// File: rtl/spm_bank_ram.sv
module spm_bank_ram
    import spm_dp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bank_req_t req,
    output word_t     rdata
);

    logic [WBYTES-1:0][7:0] mem [DEPTH];

    // Read-first: rdata takes the old word, then the enabled bytes change
    always_ff @(posedge clk) begin
        if (req.en) begin
            for (int b = 0; b < WBYTES; b++) begin
                if (req.bwe[b]) begin
                    mem[req.off][b] <= req.wdata[b*8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (req.en) begin
            rdata <= mem[req.off];
        end
    end

endmodule

// File: rtl/spm_ctrl_delay.sv
module spm_ctrl_delay
    import spm_dp_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [LANES-1:0]             served,
    input  logic [LANES-1:0][BANK_W-1:0] bank_idx,
    input  logic                         last,
    output logic [LANES-1:0]             served_d,
    output logic [LANES-1:0][BANK_W-1:0] bank_idx_d,
    output logic                         last_d
);

    // One stage, matching the one-cycle bank read latency
    always_ff @(posedge clk) begin
        if (rst) begin
            served_d   <= '0;
            bank_idx_d <= '0;
            last_d     <= 1'b0;
        end else begin
            served_d   <= served;
            bank_idx_d <= bank_idx;
            last_d     <= last;
        end
    end

endmodule

// File: rtl/spm_out_xbar.sv
module spm_out_xbar
    import spm_dp_pkg::*;
(
    input  logic [BANKS-1:0][DATA_W-1:0] bank_rd,
    input  logic [LANES-1:0][BANK_W-1:0] sel,
    output logic [LANES-1:0][DATA_W-1:0] lane_rd
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane_mux
        assign lane_rd[l] = bank_rd[sel[l]];
    end

endmodule

// File: rtl/spm_collector.sv
module spm_collector
    import spm_dp_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [LANES-1:0]             load,
    input  logic                         last,
    input  logic [LANES-1:0][DATA_W-1:0] lane_rd,
    output logic                         valid,
    output logic [LANES-1:0][DATA_W-1:0] result
);

    for (genvar l = 0; l < LANES; l++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                result[l] <= '0;
            end else if (load[l]) begin
                result[l] <= lane_rd[l];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
        end else begin
            valid <= last;
        end
    end

endmodule

// File: rtl/spm_bank_datapath.sv
module spm_bank_datapath
    import spm_dp_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [LANES-1:0]             in_served,
    input  logic [LANES-1:0][BANK_W-1:0] in_bank_idx,
    input  logic [LANES-1:0][OFF_W-1:0]  in_offset,
    input  logic [LANES-1:0][DATA_W-1:0] in_wdata,
    input  logic [LANES-1:0][WBYTES-1:0] in_bmask,
    input  logic                         in_store,
    input  logic                         in_last,
    output logic                         out_valid,
    output logic [LANES-1:0][DATA_W-1:0] out_rdata
);

    bank_req_t                    bank_req [BANKS];
    logic [BANKS-1:0]             bank_en;
    logic [BANKS-1:0][DATA_W-1:0] bank_rd;
    logic [LANES-1:0]             served_d;
    logic [LANES-1:0][BANK_W-1:0] bank_idx_d;
    logic                         last_d;
    logic [LANES-1:0][DATA_W-1:0] lane_rd;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        spm_bank_steer #(.BANK_ID(b)) u_steer (
            .served   (in_served),
            .bank_idx (in_bank_idx),
            .offset   (in_offset),
            .wdata    (in_wdata),
            .bmask    (in_bmask),
            .store    (in_store),
            .req      (bank_req[b])
        );

        spm_bank_ram u_ram (
            .clk   (clk),
            .rst   (rst),
            .req   (bank_req[b]),
            .rdata (bank_rd[b])
        );

        assign bank_en[b] = bank_req[b].en;
    end

    spm_ctrl_delay u_delay (
        .clk        (clk),
        .rst        (rst),
        .served     (in_served),
        .bank_idx   (in_bank_idx),
        .last       (in_last),
        .served_d   (served_d),
        .bank_idx_d (bank_idx_d),
        .last_d     (last_d)
    );

    spm_out_xbar u_xbar (
        .bank_rd (bank_rd),
        .sel     (bank_idx_d),
        .lane_rd (lane_rd)
    );

    spm_collector u_coll (
        .clk     (clk),
        .rst     (rst),
        .load    (served_d),
        .last    (last_d),
        .lane_rd (lane_rd),
        .valid   (out_valid),
        .result  (out_rdata)
    );

endmodule

// File: rtl/spm_dp_checker.sv
module spm_dp_checker
    import spm_dp_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic [LANES-1:0]             in_served,
    input logic                         in_last,
    input logic [BANKS-1:0]             bank_en,
    input logic                         out_valid,
    input logic [LANES-1:0][DATA_W-1:0] out_rdata
);

    AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        in_last |=> ##1 out_valid); // R7

    AST_VALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_last, 2)); // R7

    AST_BANK_NEEDS_SERVED: assert property (@(posedge clk) disable iff (rst)
        (|bank_en) |-> (|in_served)); // R9

    AST_SERVED_USES_BANK: assert property (@(posedge clk) disable iff (rst)
        (|in_served) |-> (|bank_en)); // R2

    AST_BANK_COUNT: assert property (@(posedge clk) disable iff (rst)
        $countones(bank_en) <= $countones(in_served)); // R2

    for (genvar l = 0; l < LANES; l++) begin : g_hold
        AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!$stable(out_rdata[l]) && !$past(rst)) |-> $past(in_served[l], 2)); // R6
    end

endmodule

bind spm_bank_datapath spm_dp_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_served (in_served),
    .in_last   (in_last),
    .bank_en   (bank_en),
    .out_valid (out_valid),
    .out_rdata (out_rdata)
);

// File: tb/tb_spm_bank_datapath.sv
module tb_spm_bank_datapath;
    import spm_dp_pkg::*;

    logic                         clk = 1'b0;
    logic                         rst;
    logic [LANES-1:0]             served;
    logic [LANES-1:0][BANK_W-1:0] bidx;
    logic [LANES-1:0][OFF_W-1:0]  boff;
    logic [LANES-1:0][DATA_W-1:0] wd;
    logic [LANES-1:0][WBYTES-1:0] bm;
    logic                         store;
    logic                         last;
    logic                         valid;
    logic [LANES-1:0][DATA_W-1:0] rd;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    spm_bank_datapath dut (
        .clk(clk), .rst(rst), .in_served(served), .in_bank_idx(bidx),
        .in_offset(boff), .in_wdata(wd), .in_bmask(bm), .in_store(store),
        .in_last(last), .out_valid(valid), .out_rdata(rd)
    );

    task automatic chk_word(input string req, input int lane, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s lane %0d: got %h expected %h", req, lane, got, exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s valid: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic idle();
        served = '0; bidx = '0; boff = '0; wd = '0; bm = '0; store = 0; last = 0;
    endtask

    // Drive one cycle at a negedge; return at the next negedge with inputs idle
    task automatic drive(input logic [3:0] s, input logic [3:0][1:0] i, input logic [3:0][3:0] o,
                         input logic [3:0][31:0] d, input logic [3:0][3:0] m,
                         input logic st, input logic lt);
        served = s; bidx = i; boff = o; wd = d; bm = m; store = st; last = lt;
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    localparam logic [3:0][1:0] IDX_ID = {2'd3, 2'd2, 2'd1, 2'd0};
    localparam logic [3:0][3:0] OFF5   = {4'd5, 4'd5, 4'd5, 4'd5};
    localparam logic [3:0][3:0] FULL   = {4'hF, 4'hF, 4'hF, 4'hF};

    task automatic t_reset();
        chk_bit("R1", valid, 1'b0);
        for (int l = 0; l < 4; l++) chk_word("R1", l, rd[l], 32'h0);
    endtask

    task automatic t_read_first();
        drive(4'hF, IDX_ID, OFF5, {32'h11110003, 32'h11110002, 32'h11110001, 32'h11110000}, FULL, 1, 1);
        step();
        chk_bit("R7", valid, 1'b1);
        step();
        chk_bit("R7", valid, 1'b0);
        drive(4'hF, IDX_ID, OFF5, {32'h22220003, 32'h22220002, 32'h22220001, 32'h22220000}, FULL, 1, 1);
        step();
        for (int l = 0; l < 4; l++) chk_word("R4", l, rd[l], 32'h11110000 + l);
        drive(4'hF, IDX_ID, OFF5, '0, '0, 0, 1);
        step();
        chk_bit("R8", valid, 1'b1);
        for (int l = 0; l < 4; l++) chk_word("R8", l, rd[l], 32'h22220000 + l);
    endtask

    task automatic t_byte_mask();
        drive(4'b0001, '0, OFF5, {96'h0, 32'hFFFFFFFF}, {12'h0, 4'b0101}, 1, 1);
        step();
        chk_word("R4", 0, rd[0], 32'h22220000);
        for (int l = 1; l < 4; l++) chk_word("R6", l, rd[l], 32'h22220000 + l);
        drive(4'b0001, '0, OFF5, '0, '0, 0, 1);
        step();
        chk_word("R3", 0, rd[0], 32'h22FF00FF);
    endtask

    task automatic t_steer();
        drive(4'b0101, {2'd0, 2'd1, 2'd0, 2'd1}, {4'd0, 4'd7, 4'd0, 4'd7},
              {32'h0, 32'hBBBB0002, 32'h0, 32'hAAAA0001}, FULL, 1, 1);
        step();
        drive(4'b0010, {2'd0, 2'd0, 2'd1, 2'd0}, {4'd0, 4'd0, 4'd7, 4'd0}, '0, '0, 0, 1);
        step();
        chk_word("R2", 1, rd[1], 32'hAAAA0001);
    endtask

    task automatic t_unserved();
        drive(4'b0010, {2'd0, 2'd0, 2'd2, 2'd0}, {4'd0, 4'd0, 4'd9, 4'd0},
              {32'h0, 32'h0, 32'hC0C01234, 32'h0}, FULL, 1, 1);
        step();
        // lane 3 names bank 2 offset 9 with a full mask but is not served
        drive(4'b0001, {2'd2, 2'd0, 2'd0, 2'd0}, {4'd9, 4'd0, 4'd0, 4'd9},
              {32'hDEADBEEF, 32'h0, 32'h0, 32'h00005555}, FULL, 1, 1);
        step();
        drive(4'b0101, {2'd0, 2'd2, 2'd0, 2'd0}, {4'd0, 4'd9, 4'd0, 4'd9}, '0, '0, 0, 1);
        step();
        chk_word("R9", 2, rd[2], 32'hC0C01234);
        chk_word("R2", 0, rd[0], 32'h00005555);
    endtask

    task automatic t_broadcast();
        drive(4'hF, {4{2'd2}}, {4{4'd9}}, '0, '0, 0, 1);
        step();
        for (int l = 0; l < 4; l++) chk_word("R5", l, rd[l], 32'hC0C01234);
    endtask

    task automatic t_serial();
        drive(4'b0011, {2'd0, 2'd0, 2'd0, 2'd1}, {4'd0, 4'd0, 4'd5, 4'd7}, '0, '0, 0, 0);
        drive(4'b1100, {2'd3, 2'd1, 2'd0, 2'd0}, {4'd5, 4'd5, 4'd0, 4'd0}, '0, '0, 0, 1);
        chk_bit("R7", valid, 1'b0);
        step();
        chk_bit("R7", valid, 1'b1);
        chk_word("R6", 0, rd[0], 32'hAAAA0001);
        chk_word("R6", 1, rd[1], 32'h22FF00FF);
        chk_word("R8", 2, rd[2], 32'h22220001);
        chk_word("R8", 3, rd[3], 32'h22220003);
    endtask

    task automatic t_back_to_back();
        drive(4'b0001, {2'd0, 2'd0, 2'd0, 2'd3}, OFF5, '0, '0, 0, 1);
        drive(4'b0001, {2'd0, 2'd0, 2'd0, 2'd2}, {4'd0, 4'd0, 4'd0, 4'd9}, '0, '0, 0, 1);
        chk_bit("R7", valid, 1'b1);
        chk_word("R8", 0, rd[0], 32'h22220003);
        step();
        chk_bit("R7", valid, 1'b1);
        chk_word("R8", 0, rd[0], 32'hC0C01234);
        chk_word("R6", 1, rd[1], 32'h22FF00FF);
        chk_word("R6", 3, rd[3], 32'h22220003);
        step();
        chk_bit("R7", valid, 1'b0);
    endtask

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_first();
        t_byte_mask();
        t_steer();
        t_unserved();
        t_broadcast();
        t_serial();
        t_back_to_back();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule